// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block loads a configuration image into a target FPGA through a byte-wide slave-parallel port. A host gives a start pulse and a byte count, then streams the image in over a valid/ready handshake. The loader pulses the target's active-low program pin, waits until the target reports it is ready (INIT high, BUSY low), and then moves the image one byte per configuration clock edge with chip-select and write-enable held low.

When BUSY checking is enabled and the target raises BUSY after an edge, the loader keeps pulsing the configuration clock with the same byte on the bus until BUSY drops. After the last byte it raises chip-select first and write-enable one cycle later, and then it keeps pulsing the clock until the target raises DONE. Every wait (ready, BUSY stall, DONE) has its own timeout. When a timeout expires, the loader drives a fixed abort pattern on the control pins and reports failure together with a code for the phase that timed out.

The target pins are assumed to be synchronous to the loader clock. All outputs toward the target come straight from flip-flops.

Top module: `pcfg_loader`

## Requirements
- R1: After reset and while idle: tgt_prog_n, tgt_cs_n, tgt_wr_n and tgt_cclk are all 1, s_ready is 0, active is 0, and cfg_ok and cfg_fail are both 0.
- R2: A start pulse while idle drives tgt_prog_n low for exactly PROG_CYC cycles (one pulse per run). tgt_cs_n and tgt_wr_n stay high until tgt_init is 1 and tgt_busy is 0.
- R3: Every accepted byte is placed on tgt_d, and then tgt_cclk goes low and back high while tgt_cs_n=0 and tgt_wr_n=0. tgt_d is stable in the cycle before and the cycle after that rising edge, and the target sees the bytes in stream order.
- R4: With busy_chk_en=1, if tgt_busy is 1 in the cycle after a rising edge, the loader gives another clock pulse with the same byte and accepts no new byte until tgt_busy is 0.
- R5: With busy_chk_en=0, tgt_busy is ignored during the transfer: each byte gets exactly one rising edge.
- R6: After the last byte, tgt_cs_n rises one cycle before tgt_wr_n rises.
- R7: After both pins are released, the loader gives clock pulses until tgt_done is 1. It then sets cfg_ok and drops active. When DONE needs three rising edges, exactly three are issued.
- R8: A timeout of TIMEOUT_CYC cycles in any wait leads to an abort. The abort holds tgt_cs_n=0 and tgt_wr_n=1 for ABORT_CYC cycles, then releases both and sets cfg_fail. fail_phase is 1 for a ready-wait timeout, 2 for a BUSY-stall timeout and 3 for a DONE-wait timeout. cfg_ok and cfg_fail are never both 1.
- R9: bytes_sent goes up by one for each valid/ready handshake and is cleared at start. After a successful run it equals the byte_cnt that was requested.
- R10: A start pulse while active has no effect: the run completes normally, with a single program pulse.
- R11: A byte count of zero produces no data clock edges and goes directly to the release and DONE phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; sampled only while idle |
| byte_cnt | input | CNT_W | Number of image bytes, latched at start |
| busy_chk_en | input | 1 | 1 = stall on target BUSY after each edge |
| s_data | input | DATA_W | Image byte stream data |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Loader can take a byte this cycle |
| tgt_prog_n | output | 1 | Target program pin, active low |
| tgt_cs_n | output | 1 | Target chip-select, active low |
| tgt_wr_n | output | 1 | Target write-enable, active low |
| tgt_cclk | output | 1 | Configuration clock, idles high |
| tgt_d | output | DATA_W | Configuration data bus |
| tgt_init | input | 1 | Target ready indication (high = ready) |
| tgt_busy | input | 1 | Target busy indication |
| tgt_done | input | 1 | Target configuration finished |
| active | output | 1 | A run is in progress |
| cfg_ok | output | 1 | Last run ended with DONE |
| cfg_fail | output | 1 | Last run ended in an abort |
| fail_phase | output | 2 | Phase that timed out: 1 ready, 2 BUSY, 3 DONE |
| bytes_sent | output | CNT_W | Bytes accepted in the current or last run |

## Verification
The hardest case to reach is a BUSY stall that lasts long enough for the timer restarted at the byte's acceptance to expire while the loader is still repeating edges. The stall also has to be told apart from ordinary stalls that clear. The bench uses a behavioural target that can be told, for each byte index, how many extra edges it stays busy for. One run mixes short stalls on chosen bytes and checks the total edge count. A later run sets a stall far beyond the timeout on the first byte and expects abort code 2 after exactly one accepted byte. Separate target settings force the ready-wait and DONE-wait timeouts, and another setting holds BUSY high after the first byte with checking disabled.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PROG,
      ST_WAIT,
      ST_LOAD,
      ST_LO,
      ST_HI,
      ST_REL,
      ST_DCHK,
      ST_DLO,
      ST_ABORT
   } pcfg_state_e;

   localparam logic [1:0] PH_NONE = 2'd0;
   localparam logic [1:0] PH_RDY  = 2'd1;
   localparam logic [1:0] PH_BUSY = 2'd2;
   localparam logic [1:0] PH_DONE = 2'd3;

endpackage

// File: rtl/pcfg_timer.sv
module pcfg_timer #(
   parameter int LIMIT = 2500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (cnt_q != TW'(LIMIT))
         cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/pcfg_bytecnt.sv
module pcfg_bytecnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [CNT_W-1:0] target,
   input  logic             inc,
   output logic [CNT_W-1:0] count,
   output logic             at_end
);
   logic [CNT_W-1:0] tgt_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tgt_q <= '0;
         cnt_q <= '0;
      end else if (clear) begin
         tgt_q <= target;
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count  = cnt_q;
   assign at_end = (cnt_q == tgt_q);
endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
   import pcfg_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 16,
   parameter int PROG_CYC    = 4,
   parameter int ABORT_CYC   = 4,
   parameter int TIMEOUT_CYC = 2500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  byte_cnt,
   input  logic              busy_chk_en,
   input  logic [DATA_W-1:0] s_data,
   input  logic              s_valid,
   output logic              s_ready,
   output logic              tgt_prog_n,
   output logic              tgt_cs_n,
   output logic              tgt_wr_n,
   output logic              tgt_cclk,
   output logic [DATA_W-1:0] tgt_d,
   input  logic              tgt_init,
   input  logic              tgt_busy,
   input  logic              tgt_done,
   output logic              active,
   output logic              cfg_ok,
   output logic              cfg_fail,
   output logic [1:0]        fail_phase,
   output logic [CNT_W-1:0]  bytes_sent
);
   localparam int PH_MAX = (PROG_CYC > ABORT_CYC) ? PROG_CYC : ABORT_CYC;
   localparam int PH_W   = $clog2(PH_MAX + 1);

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_data_w
      $error("pcfg_loader: DATA_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt_w
      $error("pcfg_loader: CNT_W must be at least 1");
   end
   if (PROG_CYC < 1 || ABORT_CYC < 1) begin : g_bad_phase
      $error("pcfg_loader: PROG_CYC and ABORT_CYC must be at least 1");
   end
   if (TIMEOUT_CYC < 2) begin : g_bad_tmo
      $error("pcfg_loader: TIMEOUT_CYC must be at least 2");
   end

   pcfg_state_e       state_q, state_n;
   logic [PH_W-1:0]   ph_cnt_q;
   logic [DATA_W-1:0] data_q;
   logic              prog_n_q, cs_n_q, wr_n_q, cclk_q;
   logic              ok_q, fail_q;
   logic [1:0]        phase_q;

   logic tmr_restart, tmr_expired;
   logic cnt_clr, cnt_inc, cnt_at_end;
   logic accept;

   pcfg_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tmr_restart),
      .expired (tmr_expired)
   );

   pcfg_bytecnt #(.CNT_W(CNT_W)) u_bytecnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cnt_clr),
      .target (byte_cnt),
      .inc    (cnt_inc),
      .count  (bytes_sent),
      .at_end (cnt_at_end)
   );

   assign s_ready = (state_q == ST_LOAD) && !cnt_at_end;
   assign accept  = s_ready && s_valid;

   // next-state logic
   always_comb begin
      state_n     = state_q;
      tmr_restart = 1'b0;
      cnt_clr     = 1'b0;
      cnt_inc     = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start) begin
               state_n = ST_PROG;
               cnt_clr = 1'b1;
            end
         end
         ST_PROG: begin
            if (ph_cnt_q == PH_W'(PROG_CYC - 1)) begin
               state_n     = ST_WAIT;
               tmr_restart = 1'b1;
            end
         end
         ST_WAIT: begin
            if (tgt_init && !tgt_busy)
               state_n = ST_LOAD;
            else if (tmr_expired)
               state_n = ST_ABORT;
         end
         ST_LOAD: begin
            if (cnt_at_end) begin
               state_n = ST_REL;
            end else if (s_valid) begin
               cnt_inc     = 1'b1;
               tmr_restart = 1'b1;
               state_n     = ST_LO;
            end
         end
         ST_LO: state_n = ST_HI;
         ST_HI: begin
            if (busy_chk_en && tgt_busy)
               state_n = tmr_expired ? ST_ABORT : ST_LO;
            else
               state_n = ST_LOAD;
         end
         ST_REL: begin
            state_n     = ST_DCHK;
            tmr_restart = 1'b1;
         end
         ST_DCHK: begin
            if (tgt_done)
               state_n = ST_IDLE;
            else if (tmr_expired)
               state_n = ST_ABORT;
            else
               state_n = ST_DLO;
         end
         ST_DLO: state_n = ST_DCHK;
         ST_ABORT: begin
            if (ph_cnt_q == PH_W'(ABORT_CYC - 1))
               state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   // state, phase counter and status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ph_cnt_q <= '0;
         ok_q     <= 1'b0;
         fail_q   <= 1'b0;
         phase_q  <= PH_NONE;
      end else begin
         state_q  <= state_n;
         ph_cnt_q <= (state_n != state_q) ? '0 : ph_cnt_q + 1'b1;
         if (state_q == ST_IDLE && start) begin
            ok_q    <= 1'b0;
            fail_q  <= 1'b0;
            phase_q <= PH_NONE;
         end
         if (state_n == ST_ABORT && state_q != ST_ABORT) begin
            case (state_q)
               ST_WAIT: phase_q <= PH_RDY;
               ST_HI:   phase_q <= PH_BUSY;
               default: phase_q <= PH_DONE;
            endcase
         end
         if (state_q == ST_ABORT && state_n == ST_IDLE)
            fail_q <= 1'b1;
         if (state_q == ST_DCHK && state_n == ST_IDLE)
            ok_q <= 1'b1;
      end
   end

   // target pins registered from the next state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_n_q <= 1'b1;
         cs_n_q   <= 1'b1;
         wr_n_q   <= 1'b1;
         cclk_q   <= 1'b1;
         data_q   <= '0;
      end else begin
         prog_n_q <= (state_n != ST_PROG);
         cs_n_q   <= !(state_n inside {ST_LOAD, ST_LO, ST_HI, ST_ABORT});
         wr_n_q   <= !(state_n inside {ST_LOAD, ST_LO, ST_HI, ST_REL});
         cclk_q   <= !(state_n inside {ST_LO, ST_DLO});
         if (accept)
            data_q <= s_data;
      end
   end

   assign tgt_prog_n = prog_n_q;
   assign tgt_cs_n   = cs_n_q;
   assign tgt_wr_n   = wr_n_q;
   assign tgt_cclk   = cclk_q;
   assign tgt_d      = data_q;
   assign active     = (state_q != ST_IDLE);
   assign cfg_ok     = ok_q;
   assign cfg_fail   = fail_q;
   assign fail_phase = phase_q;
endmodule

// File: rtl/pcfg_loader_chk.sv
module pcfg_loader_chk #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_chk_en,
   input logic              s_valid,
   input logic              s_ready,
   input logic              tgt_prog_n,
   input logic              tgt_cs_n,
   input logic              tgt_wr_n,
   input logic              tgt_cclk,
   input logic [DATA_W-1:0] tgt_d,
   input logic              tgt_busy,
   input logic              active,
   input logic              cfg_ok,
   input logic              cfg_fail,
   input logic [1:0]        fail_phase,
   input logic [CNT_W-1:0]  bytes_sent
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (tgt_cs_n && tgt_wr_n && tgt_prog_n && !s_ready));

   p_prog_no_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tgt_prog_n |-> (tgt_cs_n && tgt_wr_n));

   p_data_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_cclk) && !tgt_wr_n) |-> $stable(tgt_d));

   p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_cclk) && !tgt_wr_n) |=> $stable(tgt_d));

   p_busy_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_cclk) && !tgt_wr_n && !tgt_cs_n && busy_chk_en && tgt_busy)
      |=> (!tgt_cclk || tgt_wr_n) && !s_ready);

   p_release_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(tgt_cs_n) && !tgt_wr_n) |=> tgt_wr_n);

   p_ok_fail_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_ok && cfg_fail));

   p_fail_coded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_fail |-> (fail_phase != 2'd0));

   p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |=> (bytes_sent == $past(bytes_sent) + 1'b1));
endmodule

bind pcfg_loader pcfg_loader_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_chk_en (busy_chk_en),
   .s_valid     (s_valid),
   .s_ready     (s_ready),
   .tgt_prog_n  (tgt_prog_n),
   .tgt_cs_n    (tgt_cs_n),
   .tgt_wr_n    (tgt_wr_n),
   .tgt_cclk    (tgt_cclk),
   .tgt_d       (tgt_d),
   .tgt_busy    (tgt_busy),
   .active      (active),
   .cfg_ok      (cfg_ok),
   .cfg_fail    (cfg_fail),
   .fail_phase  (fail_phase),
   .bytes_sent  (bytes_sent)
);

// File: tb/pcfg_loader_bench.sv
`timescale 1ns/1ps
module pcfg_loader_bench;
   localparam int DW  = 8;
   localparam int CW  = 16;
   localparam int TMO = 300;
   localparam int ABC = 4;
   localparam int PGC = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [CW-1:0] byte_cnt = '0;
   logic busy_chk_en = 1'b1;
   logic [DW-1:0] s_data = '0;
   logic s_valid = 1'b0;
   logic s_ready;
   logic tgt_prog_n, tgt_cs_n, tgt_wr_n, tgt_cclk;
   logic [DW-1:0] tgt_d;
   logic tgt_init = 1'b0;
   logic tgt_busy;
   logic tgt_done;
   logic active, cfg_ok, cfg_fail;
   logic [1:0] fail_phase;
   logic [CW-1:0] bytes_sent;

   always #2 clk = ~clk;

   pcfg_loader #(.DATA_W(DW), .CNT_W(CW), .PROG_CYC(PGC), .ABORT_CYC(ABC),
                 .TIMEOUT_CYC(TMO)) u_pcfg_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .byte_cnt(byte_cnt),
      .busy_chk_en(busy_chk_en), .s_data(s_data), .s_valid(s_valid),
      .s_ready(s_ready), .tgt_prog_n(tgt_prog_n), .tgt_cs_n(tgt_cs_n),
      .tgt_wr_n(tgt_wr_n), .tgt_cclk(tgt_cclk), .tgt_d(tgt_d),
      .tgt_init(tgt_init), .tgt_busy(tgt_busy), .tgt_done(tgt_done),
      .active(active), .cfg_ok(cfg_ok), .cfg_fail(cfg_fail),
      .fail_phase(fail_phase), .bytes_sent(bytes_sent)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   // scoreboard queues and target model state
   logic [DW-1:0] exp_q[$];
   logic [DW-1:0] src_q[$];
   int  stall_tab[16];
   int  busy_cnt = 0;
   int  edges = 0;
   int  post_edges = 0;
   int  cap_idx = 0;
   bit  stuck_mode = 0;
   bit  init_never = 0;
   bit  done_never = 0;
   int  done_need = 3;
   int  init_ctr = 0;

   assign tgt_busy = (busy_cnt > 0) || (stuck_mode && cap_idx > 0);
   assign tgt_done = !done_never && (post_edges >= done_need);

   // target readiness model
   always @(posedge clk) begin
      if (!tgt_prog_n) begin
         tgt_init <= 1'b0;
         init_ctr <= 0;
      end else if (!init_never) begin
         if (init_ctr < 5) init_ctr <= init_ctr + 1;
         else tgt_init <= 1'b1;
      end
   end

   // monitor: target capture on rising configuration clock
   always @(posedge tgt_cclk) begin
      if (!tgt_cs_n && !tgt_wr_n) begin
         edges++;
         if (busy_cnt > 0) begin
            busy_cnt--;
         end else begin
            if (exp_q.size() > 0) begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               check(tgt_d == e, "R3 byte order/value", int'(tgt_d), int'(e));
            end else begin
               check(1'b0, "R3 unexpected byte", int'(tgt_d), -1);
            end
            if (!stuck_mode && cap_idx < 16) busy_cnt = stall_tab[cap_idx];
            cap_idx++;
         end
      end else if (tgt_cs_n && tgt_wr_n) begin
         post_edges++;
      end
   end

   // pin-sequence monitors
   int  prog_pulses = 0, prog_run = 0, prog_len = 0;
   int  ab_run = 0, ab_len = 0;
   int  rel_seen = 0, rel_bad = 0, cs_early = 0;
   bit  wait_wr = 0, prev_cs = 1, prev_prog = 1;
   always @(negedge clk) begin
      if (!tgt_prog_n) prog_run++;
      else if (prog_run > 0) begin prog_len = prog_run; prog_run = 0; end
      if (prev_prog && !tgt_prog_n) prog_pulses++;
      prev_prog = tgt_prog_n;
      if (active && !tgt_cs_n && tgt_wr_n) ab_run++;
      else begin if (ab_run > 0) ab_len = ab_run; ab_run = 0; end
      if (wait_wr) begin if (!tgt_wr_n) rel_bad++; wait_wr = 0; end
      if (!prev_cs && tgt_cs_n && !tgt_wr_n) begin rel_seen++; wait_wr = 1; end
      prev_cs = tgt_cs_n;
      if (!tgt_cs_n && !tgt_wr_n && !tgt_init) cs_early++;
   end

   // stream driver
   bit rdy_prev = 0;
   int gap = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (s_valid && rdy_prev && src_q.size() > 0) void'(src_q.pop_front());
         rdy_prev = s_ready;
         gap++;
         if (src_q.size() > 0 && (gap % 4) != 3) begin
            s_valid = 1'b1;
            s_data  = src_q[0];
         end else begin
            s_valid = 1'b0;
         end
      end
   end

   // driver: push expected items, start a run, wait for completion
   task automatic run(input int n, input bit en, input int pat, input int restart_at);
      exp_q.delete(); src_q.delete();
      for (int i = 0; i < n; i++) begin
         logic [DW-1:0] b;
         b = DW'(pat * 37 + i * 11 + 5);
         exp_q.push_back(b);
         src_q.push_back(b);
      end
      busy_cnt = 0; edges = 0; post_edges = 0; cap_idx = 0;
      prog_pulses = 0; ab_len = 0; rel_seen = 0; rel_bad = 0; cs_early = 0;
      byte_cnt = CW'(n);
      busy_chk_en = en;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (restart_at > 0) begin
         repeat (restart_at) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      for (int k = 0; k < 20000 && active; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      src_q.delete();
   endtask

   task automatic clear_stalls();
      for (int i = 0; i < 16; i++) stall_tab[i] = 0;
   endtask

   initial begin
      clear_stalls();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(tgt_prog_n && tgt_cs_n && tgt_wr_n && tgt_cclk, "R1 pins idle",
            {tgt_prog_n, tgt_cs_n, tgt_wr_n, tgt_cclk}, 15);
      check(!s_ready && !active && !cfg_ok && !cfg_fail, "R1 status idle",
            {s_ready, active, cfg_ok, cfg_fail}, 0);

      // plain load with busy checking
      run(8, 1'b1, 1, 0);
      check(cfg_ok && !cfg_fail, "R7 success", {cfg_ok, cfg_fail}, 2);
      check(bytes_sent == 8, "R9 count", int'(bytes_sent), 8);
      check(edges == 8, "R3 one edge per byte", edges, 8);
      check(prog_len == PGC, "R2 program width", prog_len, PGC);
      check(prog_pulses == 1, "R2 single program pulse", prog_pulses, 1);
      check(cs_early == 0, "R2 select before ready", cs_early, 0);
      check(rel_seen == 1 && rel_bad == 0, "R6 release order", rel_bad, 0);
      check(post_edges == 3, "R7 DONE pulses", post_edges, 3);
      check(exp_q.size() == 0, "R3 all bytes seen", exp_q.size(), 0);
      check(!tgt_cs_n && 1'b0 || tgt_cs_n, "R1 idle after run", int'(tgt_cs_n), 1);

      // short BUSY stalls with checking on
      clear_stalls(); stall_tab[1] = 2; stall_tab[4] = 3;
      run(6, 1'b1, 2, 0);
      check(cfg_ok, "R4 success with stalls", int'(cfg_ok), 1);
      check(edges == 11, "R4 repeated edges", edges, 11);
      check(bytes_sent == 6, "R4 count with stalls", int'(bytes_sent), 6);
      check(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
      clear_stalls();

      // BUSY held high with checking off
      stuck_mode = 1;
      run(5, 1'b0, 3, 0);
      stuck_mode = 0;
      check(cfg_ok, "R5 success busy ignored", int'(cfg_ok), 1);
      check(edges == 5, "R5 one edge per byte", edges, 5);
      check(bytes_sent == 5, "R5 count", int'(bytes_sent), 5);

      // zero-length image
      run(0, 1'b1, 4, 0);
      check(cfg_ok && edges == 0, "R11 zero count", edges, 0);
      check(bytes_sent == 0, "R11 count zero", int'(bytes_sent), 0);
      check(rel_seen == 1 && rel_bad == 0, "R11 release order", rel_bad, 0);

      // start while active is ignored
      run(7, 1'b1, 5, 20);
      check(cfg_ok && prog_pulses == 1, "R10 restart ignored", prog_pulses, 1);
      check(bytes_sent == 7, "R10 count", int'(bytes_sent), 7);

      // ready-wait timeout
      init_never = 1;
      run(4, 1'b1, 6, 0);
      init_never = 0;
      check(cfg_fail && !cfg_ok, "R8 ready fail", {cfg_ok, cfg_fail}, 1);
      check(fail_phase == 2'd1, "R8 ready phase", int'(fail_phase), 1);
      check(ab_len == ABC, "R8 abort width", ab_len, ABC);
      check(edges == 0 && bytes_sent == 0, "R8 nothing sent", edges, 0);

      // BUSY-stall timeout
      stall_tab[0] = 1000;
      run(4, 1'b1, 7, 0);
      clear_stalls(); busy_cnt = 0;
      check(cfg_fail, "R8 busy fail", int'(cfg_fail), 1);
      check(fail_phase == 2'd2, "R8 busy phase", int'(fail_phase), 2);
      check(bytes_sent == 1, "R9 one byte before stall", int'(bytes_sent), 1);
      check(ab_len == ABC, "R8 abort width busy", ab_len, ABC);

      // DONE-wait timeout
      done_never = 1;
      run(3, 1'b1, 8, 0);
      done_never = 0;
      check(cfg_fail, "R8 done fail", int'(cfg_fail), 1);
      check(fail_phase == 2'd3, "R8 done phase", int'(fail_phase), 3);
      check(post_edges > 100, "R7 pulses while waiting for DONE", post_edges, 101);
      check(bytes_sent == 3, "R9 count before done fail", int'(bytes_sent), 3);

      // recovery after a failure
      run(2, 1'b1, 9, 0);
      check(cfg_ok && !cfg_fail && fail_phase == 2'd0, "R8 status cleared at start",
            int'(fail_phase), 0);

      wrap_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      wrap_up();
   end
endmodule